// File: doc/BRIEF.md
# Radio Transceiver Sequence Controller

This block runs the control sequences of a low-rate 2.4 GHz personal-area-network radio. A host starts an operation by writing a sequence code: listen for a frame, send a frame, send a frame and then wait for its acknowledgement, measure channel energy once, or keep sensing the channel until it is clear. The controller moves through the phases of that operation. It reacts to simple handshake pulses from the modem and the RF front end, which are not part of this block. When the operation ends, it raises one sequence-done pulse together with four status flags: channel busy, timeout, synthesizer unlock and frame pending.

A free-running symbol timer counts 16 µs symbols. The count is 24 bits wide and wraps. A compare register can end a sequence early when the count reaches it. For the send-and-acknowledge operation, the controller arms this compare on its own. The duration is built from the transmitter warm-up time, the header time, the frame length and the acknowledgement wait. The host can also arm the compare with a duration of its own.

An abort, taken either from a dedicated input or from writing the idle code, returns the controller to idle at once. It raises no done pulse, clears the status flags and disarms the compare.

Top module: `rsq_ctrl`

## Requirements
- R1: After reset the running code is 0 (idle), `done_o`, all status flags, `tx_req_o` and `cmp_en_o` are 0, and the symbol count is 0.
- R2: A write while idle starts a sequence for codes 1 (receive), 2 (transmit), 3 (energy detect), 4 (transmit then wait for acknowledgement) and 5 (repeat channel sensing until clear). `seq_code_o` shows the running code from the next cycle. Codes 6 and 7 are ignored. A nonzero write while a sequence runs is ignored.
- R3: The symbol count advances by exactly 1 every `SYM_DIV` clocks and wraps modulo 2^24.
- R4: A sequence ends with `done_o` high for exactly one cycle, in the cycle after the ending input. The flags are valid with that pulse. They hold until the next sequence start, which clears them.
- R5: With channel-check-before-send enabled, codes 2 and 4 first wait for `cca_done_i`. If `cca_busy_i` is high, the sequence ends with the busy flag set and `tx_req_o` never rises. Code 3 ends on `cca_done_i` and reports `cca_busy_i` in the busy flag. Code 5 ends only on a `cca_done_i` with `cca_busy_i` low.
- R6: Starting code 4 arms the compare to the current count plus W + 12 + 2·L + 10 + 54. W is the warm-up in µs divided by 16, plus 1 when its low 4 bits are nonzero. L is the frame length including the 2-byte checksum.
- R7: A compare hit ends the sequence with the timeout flag and disarms the compare. This happens only when `tmo_stop_en_i` is high, the sequence is not code 2, and no frame or acknowledgement arrives in the same cycle. If a frame arrives in that cycle, the sequence completes normally.
- R8: Synthesizer unlock ends any running sequence with only the unlock flag set. It wins over a timeout and over normal completion.
- R9: In code 4, an arriving acknowledgement ends the sequence and reports its frame-pending bit in the pending flag.
- R10: An arm request, from the host or from code 4, loads current count plus duration and enables the compare. It is refused, leaving the compare unchanged, when the compare is already enabled and it is at most 1 symbol ahead of the count (modulo 2^24).
- R11: `abort_i`, or a write of code 0, returns the controller to idle in the next cycle with no done pulse. It also clears all flags and disarms the compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_wr_i | input | 1 | Sequence code write strobe |
| seq_code_i | input | 3 | Sequence code to write |
| abort_i | input | 1 | Force back to idle |
| cca_bfr_tx_i | input | 1 | Check channel before sending |
| tmo_stop_en_i | input | 1 | Allow a compare hit to end the sequence |
| warmup_us_i | input | WU_W | Transmitter warm-up time in µs |
| frame_len_i | input | LEN_W | Frame length in bytes, checksum included |
| arm_req_i | input | 1 | Host request to arm the compare |
| arm_dur_i | input | TIME_W | Host arm duration in symbols |
| cca_done_i | input | 1 | Channel measurement finished |
| cca_busy_i | input | 1 | Channel found busy (with `cca_done_i`) |
| tx_done_i | input | 1 | Frame sent |
| rx_frame_i | input | 1 | Frame received |
| ack_rx_i | input | 1 | Acknowledgement received |
| ack_fp_i | input | 1 | Frame-pending bit of that acknowledgement |
| pll_unlock_i | input | 1 | Synthesizer lost lock |
| seq_code_o | output | 3 | Running sequence code, 0 when idle |
| tx_req_o | output | 1 | Sending phase active |
| done_o | output | 1 | One-cycle sequence-done pulse |
| st_cca_o | output | 1 | Channel busy flag |
| st_tmo_o | output | 1 | Timeout flag |
| st_unlock_o | output | 1 | Synthesizer unlock flag |
| st_pend_o | output | 1 | Frame pending flag |
| evt_time_o | output | TIME_W | Symbol count |
| cmp_val_o | output | TIME_W | Compare value |
| cmp_en_o | output | 1 | Compare armed |

## Verification
Each of the five sequence codes is run with the handshake orders that end it in different ways. Sending is tried with the channel check off, on with a clear channel, and on with a busy channel. Together these separate normal completion from a channel-busy exit and show whether the sending phase was ever entered. Send-and-acknowledge is run once with an acknowledgement and once left to expire, using warm-up values with and without a remainder, to pin down the rounding and the length term of the armed duration. Timeout gating is tested four ways: in receive, in plain transmit, with the stop enable off, and with a frame arriving in the very cycle of the hit. An unlock arriving together with a frame and a re-arm attempt one symbol before the hit cover the two ordering rules.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_RX    = 3'd1,
        SEQ_TX    = 3'd2,
        SEQ_ED    = 3'd3,
        SEQ_TXACK = 3'd4,
        SEQ_CCCA  = 3'd5
    } seq_code_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_CHK,
        PH_TX,
        PH_ACK,
        PH_ED,
        PH_CCCA
    } phase_e;

    typedef struct packed {
        logic cca;
        logic tmo;
        logic unlock;
        logic pend;
    } flags_t;

    // symbol budget terms of the acknowledgement timeout
    localparam int HDR_SYM   = 12;
    localparam int GAP_SYM   = 10;
    localparam int ACKW_SYM  = 54;
    localparam int SYM_US_SH = 4;

endpackage

// File: rtl/rsq_ackcalc.sv
module rsq_ackcalc #(
    parameter int WU_W   = 12,
    parameter int LEN_W  = 8,
    parameter int TIME_W = 24
) (
    input  logic [WU_W-1:0]   warmup_us_i,
    input  logic [LEN_W-1:0]  frame_len_i,
    output logic [TIME_W-1:0] dur_o
);
    import rsq_pkg::*;

    logic [TIME_W-1:0] wu_sym;

    always_comb begin
        // round microseconds up to whole symbols
        wu_sym = TIME_W'(warmup_us_i >> SYM_US_SH)
               + TIME_W'(|warmup_us_i[SYM_US_SH-1:0]);
        dur_o  = wu_sym
               + TIME_W'(HDR_SYM)
               + TIME_W'({frame_len_i, 1'b0})
               + TIME_W'(GAP_SYM)
               + TIME_W'(ACKW_SYM);
    end
endmodule

// File: rtl/rsq_symtimer.sv
module rsq_symtimer #(
    parameter int SYM_DIV = 3200,
    parameter int TIME_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [TIME_W-1:0] dur_i,
    input  logic              clr_i,
    output logic [TIME_W-1:0] evt_o,
    output logic [TIME_W-1:0] cmp_o,
    output logic              cmp_en_o,
    output logic              hit_o
);
    localparam int PRE_W = (SYM_DIV > 2) ? $clog2(SYM_DIV) : 1;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [TIME_W-1:0] evt;
        logic [TIME_W-1:0] cmp;
        logic              en;
    } tmr_st_t;

    tmr_st_t tmr_d, tmr_q;
    logic [TIME_W-1:0] remain;
    logic              arm_ok;

    always_comb begin
        tmr_d  = tmr_q;
        remain = tmr_q.cmp - tmr_q.evt;
        arm_ok = !tmr_q.en || (remain > TIME_W'(1));
        if (tmr_q.pre == PRE_W'(SYM_DIV - 1)) begin
            tmr_d.pre = '0;
            tmr_d.evt = tmr_q.evt + 1'b1;
        end else begin
            tmr_d.pre = tmr_q.pre + 1'b1;
        end
        if (clr_i) begin
            tmr_d.en = 1'b0;
        end else if (arm_i && arm_ok) begin
            tmr_d.cmp = tmr_q.evt + dur_i;
            tmr_d.en  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign evt_o    = tmr_q.evt;
    assign cmp_o    = tmr_q.cmp;
    assign cmp_en_o = tmr_q.en;
    assign hit_o    = tmr_q.en && (tmr_q.evt == tmr_q.cmp);

    p_evt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.evt != $past(tmr_q.evt)) |-> (tmr_q.evt == $past(tmr_q.evt) + 1'b1))
        else $error("p_evt_step_r3");

    p_clr_disarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !tmr_q.en)
        else $error("p_clr_disarm_r11");

    p_rearm_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && !clr_i && tmr_q.en && ((tmr_q.cmp - tmr_q.evt) <= TIME_W'(1)))
        |=> $stable(tmr_q.cmp))
        else $error("p_rearm_guard_r10");
endmodule

// File: rtl/rsq_seqfsm.sv
module rsq_seqfsm (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seq_wr_i,
    input  logic [2:0]         seq_code_i,
    input  logic               abort_i,
    input  logic               cca_bfr_tx_i,
    input  logic               tmo_stop_en_i,
    input  logic               hit_i,
    input  logic               cca_done_i,
    input  logic               cca_busy_i,
    input  logic               tx_done_i,
    input  logic               rx_frame_i,
    input  logic               ack_rx_i,
    input  logic               ack_fp_i,
    input  logic               pll_unlock_i,
    output rsq_pkg::seq_code_e code_o,
    output rsq_pkg::flags_t    flags_o,
    output logic               done_o,
    output logic               tx_req_o,
    output logic               arm_o,
    output logic               clr_o
);
    import rsq_pkg::*;

    typedef struct packed {
        seq_code_e code;
        phase_e    ph;
        logic      done;
        flags_t    fl;
    } fsm_st_t;

    fsm_st_t fsm_d, fsm_q;
    logic kill, recv, code_ok;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.done = 1'b0;
        arm_o      = 1'b0;
        clr_o      = 1'b0;
        kill       = abort_i || (seq_wr_i && seq_code_i == 3'd0);
        code_ok    = (seq_code_i >= 3'd1) && (seq_code_i <= 3'd5);
        recv       = (fsm_q.ph == PH_RX && rx_frame_i) || (fsm_q.ph == PH_ACK && ack_rx_i);

        if (kill) begin
            fsm_d.code = SEQ_IDLE;
            fsm_d.ph   = PH_IDLE;
            fsm_d.fl   = '0;
            clr_o      = 1'b1;
        end else if (fsm_q.ph == PH_IDLE) begin
            if (seq_wr_i && code_ok) begin
                fsm_d.code = seq_code_e'(seq_code_i);
                fsm_d.fl   = '0;
                unique case (seq_code_e'(seq_code_i))
                    SEQ_RX:   fsm_d.ph = PH_RX;
                    SEQ_ED:   fsm_d.ph = PH_ED;
                    SEQ_CCCA: fsm_d.ph = PH_CCCA;
                    default:  fsm_d.ph = cca_bfr_tx_i ? PH_CHK : PH_TX;
                endcase
                arm_o = (seq_code_i == 3'(SEQ_TXACK));
            end
        end else if (pll_unlock_i) begin
            fsm_d.ph        = PH_IDLE;
            fsm_d.code      = SEQ_IDLE;
            fsm_d.done      = 1'b1;
            fsm_d.fl.unlock = 1'b1;
        end else if (hit_i && tmo_stop_en_i && fsm_q.code != SEQ_TX && !recv) begin
            fsm_d.ph     = PH_IDLE;
            fsm_d.code   = SEQ_IDLE;
            fsm_d.done   = 1'b1;
            fsm_d.fl.tmo = 1'b1;
            clr_o        = 1'b1;
        end else begin
            unique case (fsm_q.ph)
                PH_RX: if (rx_frame_i) begin
                    fsm_d.ph = PH_IDLE; fsm_d.code = SEQ_IDLE; fsm_d.done = 1'b1;
                end
                PH_CHK: if (cca_done_i) begin
                    if (cca_busy_i) begin
                        fsm_d.ph = PH_IDLE; fsm_d.code = SEQ_IDLE; fsm_d.done = 1'b1;
                        fsm_d.fl.cca = 1'b1;
                    end else begin
                        fsm_d.ph = PH_TX;
                    end
                end
                PH_TX: if (tx_done_i) begin
                    if (fsm_q.code == SEQ_TXACK) begin
                        fsm_d.ph = PH_ACK;
                    end else begin
                        fsm_d.ph = PH_IDLE; fsm_d.code = SEQ_IDLE; fsm_d.done = 1'b1;
                    end
                end
                PH_ACK: if (ack_rx_i) begin
                    fsm_d.ph = PH_IDLE; fsm_d.code = SEQ_IDLE; fsm_d.done = 1'b1;
                    fsm_d.fl.pend = ack_fp_i;
                end
                PH_ED: if (cca_done_i) begin
                    fsm_d.ph = PH_IDLE; fsm_d.code = SEQ_IDLE; fsm_d.done = 1'b1;
                    fsm_d.fl.cca = cca_busy_i;
                end
                PH_CCCA: if (cca_done_i && !cca_busy_i) begin
                    fsm_d.ph = PH_IDLE; fsm_d.code = SEQ_IDLE; fsm_d.done = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.code <= SEQ_IDLE;
            fsm_q.ph   <= PH_IDLE;
            fsm_q.done <= 1'b0;
            fsm_q.fl   <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign code_o   = fsm_q.code;
    assign flags_o  = fsm_q.fl;
    assign done_o   = fsm_q.done;
    assign tx_req_o = (fsm_q.ph == PH_TX);

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.done |=> !fsm_q.done)
        else $error("p_done_pulse_r4");

    p_active_no_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.code != SEQ_IDLE) |-> (fsm_q.fl == '0))
        else $error("p_active_no_flags_r4");

    p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (fsm_q.code == SEQ_IDLE && !fsm_q.done && fsm_q.fl == '0))
        else $error("p_abort_idle_r11");

    p_unlock_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.ph != PH_IDLE && pll_unlock_i && !abort_i && !(seq_wr_i && seq_code_i == 3'd0))
        |=> (fsm_q.done && fsm_q.fl.unlock && !fsm_q.fl.tmo))
        else $error("p_unlock_first_r8");

    p_plain_tx_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.code == SEQ_TX && !pll_unlock_i && !abort_i && !seq_wr_i && !tx_done_i && !cca_done_i)
        |=> (fsm_q.code == SEQ_TX))
        else $error("p_plain_tx_keeps_r7");
endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl #(
    parameter int SYM_DIV = 3200,
    parameter int TIME_W  = 24,
    parameter int WU_W    = 12,
    parameter int LEN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_wr_i,
    input  logic [2:0]        seq_code_i,
    input  logic              abort_i,
    input  logic              cca_bfr_tx_i,
    input  logic              tmo_stop_en_i,
    input  logic [WU_W-1:0]   warmup_us_i,
    input  logic [LEN_W-1:0]  frame_len_i,
    input  logic              arm_req_i,
    input  logic [TIME_W-1:0] arm_dur_i,
    input  logic              cca_done_i,
    input  logic              cca_busy_i,
    input  logic              tx_done_i,
    input  logic              rx_frame_i,
    input  logic              ack_rx_i,
    input  logic              ack_fp_i,
    input  logic              pll_unlock_i,
    output logic [2:0]        seq_code_o,
    output logic              tx_req_o,
    output logic              done_o,
    output logic              st_cca_o,
    output logic              st_tmo_o,
    output logic              st_unlock_o,
    output logic              st_pend_o,
    output logic [TIME_W-1:0] evt_time_o,
    output logic [TIME_W-1:0] cmp_val_o,
    output logic              cmp_en_o
);
    import rsq_pkg::*;

    seq_code_e         code;
    flags_t            flags;
    logic              fsm_arm, fsm_clr, hit;
    logic              arm_go;
    logic [TIME_W-1:0] ack_dur, arm_dur;

    rsq_ackcalc #(.WU_W(WU_W), .LEN_W(LEN_W), .TIME_W(TIME_W)) u_ackcalc (
        .warmup_us_i (warmup_us_i),
        .frame_len_i (frame_len_i),
        .dur_o       (ack_dur)
    );

    // the sequencer's own arm request takes the port over the host's
    assign arm_go  = fsm_arm || arm_req_i;
    assign arm_dur = fsm_arm ? ack_dur : arm_dur_i;

    rsq_symtimer #(.SYM_DIV(SYM_DIV), .TIME_W(TIME_W)) u_symtimer (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm_go),
        .dur_i    (arm_dur),
        .clr_i    (fsm_clr),
        .evt_o    (evt_time_o),
        .cmp_o    (cmp_val_o),
        .cmp_en_o (cmp_en_o),
        .hit_o    (hit)
    );

    rsq_seqfsm u_seqfsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .seq_wr_i      (seq_wr_i),
        .seq_code_i    (seq_code_i),
        .abort_i       (abort_i),
        .cca_bfr_tx_i  (cca_bfr_tx_i),
        .tmo_stop_en_i (tmo_stop_en_i),
        .hit_i         (hit),
        .cca_done_i    (cca_done_i),
        .cca_busy_i    (cca_busy_i),
        .tx_done_i     (tx_done_i),
        .rx_frame_i    (rx_frame_i),
        .ack_rx_i      (ack_rx_i),
        .ack_fp_i      (ack_fp_i),
        .pll_unlock_i  (pll_unlock_i),
        .code_o        (code),
        .flags_o       (flags),
        .done_o        (done_o),
        .tx_req_o      (tx_req_o),
        .arm_o         (fsm_arm),
        .clr_o         (fsm_clr)
    );

    assign seq_code_o  = code;
    assign st_cca_o    = flags.cca;
    assign st_tmo_o    = flags.tmo;
    assign st_unlock_o = flags.unlock;
    assign st_pend_o   = flags.pend;

    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (seq_code_o == 3'd0))
        else $error("p_done_idle_r4");
endmodule

// File: tb/rsq_ctrl_bench.sv
module rsq_ctrl_bench;
    localparam int DIV = 4;
    localparam int TW  = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seq_wr = 0, abort = 0, cca_bfr = 0, tmo_en = 1, arm_req = 0;
    logic [2:0] seq_code = 0;
    logic [11:0] warmup = 0;
    logic [7:0] flen = 0;
    logic [TW-1:0] arm_dur = 0;
    logic cca_done = 0, cca_busy = 0, tx_done = 0, rx_frame = 0, ack_rx = 0, ack_fp = 0, unlock = 0;
    logic [2:0] code_o;
    logic tx_req, done, f_cca, f_tmo, f_unl, f_pend, cmp_en;
    logic [TW-1:0] evt, cmpv;

    always #2.5 clk = ~clk;

    rsq_ctrl #(.SYM_DIV(DIV)) u_rsq_ctrl (
        .clk(clk), .rst_n(rst_n), .seq_wr_i(seq_wr), .seq_code_i(seq_code),
        .abort_i(abort), .cca_bfr_tx_i(cca_bfr), .tmo_stop_en_i(tmo_en),
        .warmup_us_i(warmup), .frame_len_i(flen), .arm_req_i(arm_req),
        .arm_dur_i(arm_dur), .cca_done_i(cca_done), .cca_busy_i(cca_busy),
        .tx_done_i(tx_done), .rx_frame_i(rx_frame), .ack_rx_i(ack_rx),
        .ack_fp_i(ack_fp), .pll_unlock_i(unlock), .seq_code_o(code_o),
        .tx_req_o(tx_req), .done_o(done), .st_cca_o(f_cca), .st_tmo_o(f_tmo),
        .st_unlock_o(f_unl), .st_pend_o(f_pend), .evt_time_o(evt),
        .cmp_val_o(cmpv), .cmp_en_o(cmp_en)
    );

    int n_chk = 0, n_bad = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];
    bit         finished = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_done(string req, logic [3:0] fl);
        exp_q.push_back(fl);
        tag_q.push_back(req);
    endtask

    // scoreboard monitor: flags {busy,timeout,unlock,pending}
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R4 unexpected done actual=%0h expected=none",
                         {f_cca, f_tmo, f_unl, f_pend});
            end else begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({f_cca, f_tmo, f_unl, f_pend} !== e) begin
                    n_bad++;
                    $display("FAIL %s flags actual=%0h expected=%0h", t,
                             {f_cca, f_tmo, f_unl, f_pend}, e);
                end
            end
        end
    end

    task automatic start(logic [2:0] c);
        @(negedge clk); seq_wr = 1; seq_code = c;
        @(negedge clk); seq_wr = 0;
    endtask

    task automatic wait_sb(int lim);
        for (int i = 0; i < lim && exp_q.size() != 0; i++) @(negedge clk);
        @(negedge clk);
        chk("R4 scoreboard drained", exp_q.size(), 0);
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 150000 && !finished; i++) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        logic [TW-1:0] e0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 code", code_o, 0);
        chk("R1 flags", {done, f_cca, f_tmo, f_unl, f_pend, tx_req, cmp_en}, 0);
        chk("R1 count", evt, 0);

        // R3 symbol count step
        e0 = evt;
        repeat (5 * DIV) @(negedge clk);
        chk("R3 count advance", evt, e0 + 5);

        // R2 receive
        start(1);
        chk("R2 receive code", code_o, 1);
        expect_done("R2 rx done", 4'b0000);
        rx_frame = 1; @(negedge clk); rx_frame = 0;
        chk("R4 idle after done", code_o, 0);

        // R5 transmit without channel check
        cca_bfr = 0;
        start(2);
        chk("R5 tx direct", tx_req, 1);
        expect_done("R2 tx done", 4'b0000);
        tx_done = 1; @(negedge clk); tx_done = 0;

        // R5 transmit with busy channel
        cca_bfr = 1;
        start(2);
        chk("R5 waiting for check", tx_req, 0);
        expect_done("R5 busy", 4'b1000);
        cca_busy = 1; cca_done = 1; @(negedge clk); cca_done = 0; cca_busy = 0;
        chk("R5 never sent", tx_req, 0);

        // R5 transmit with clear channel
        start(2);
        cca_done = 1; @(negedge clk); cca_done = 0;
        chk("R5 clear then send", tx_req, 1);
        expect_done("R5 clear tx", 4'b0000);
        tx_done = 1; @(negedge clk); tx_done = 0;

        // R5 energy detect reports busy; R4 flags hold then clear on start
        start(3);
        expect_done("R5 ed busy", 4'b1000);
        cca_busy = 1; cca_done = 1; @(negedge clk); cca_done = 0; cca_busy = 0;
        repeat (4) @(negedge clk);
        chk("R4 flag holds", f_cca, 1);
        start(1);
        chk("R4 flag cleared by start", f_cca, 0);
        start(0);
        chk("R11 code 0 write aborts", code_o, 0);

        // R5 continuous sensing
        start(5);
        cca_busy = 1; cca_done = 1; @(negedge clk); cca_done = 0; cca_busy = 0;
        @(negedge clk);
        chk("R5 ccca stays on busy", code_o, 5);
        expect_done("R5 ccca clear", 4'b0000);
        cca_done = 1; @(negedge clk); cca_done = 0;

        // R2 ignored codes and busy writes
        start(6);
        chk("R2 code 6 ignored", code_o, 0);
        start(1);
        start(2);
        chk("R2 busy write ignored", code_o, 1);
        abort = 1; @(negedge clk); abort = 0;

        // R6 / R9 transmit then acknowledgement
        cca_bfr = 0; warmup = 12'd100; flen = 8'd10;
        @(negedge clk); seq_wr = 1; seq_code = 4; e0 = evt;
        @(negedge clk); seq_wr = 0;
        chk("R6 ack timeout rounded", cmpv, e0 + 103);
        chk("R6 armed", cmp_en, 1);
        tx_done = 1; @(negedge clk); tx_done = 0;
        expect_done("R9 pending", 4'b0001);
        ack_fp = 1; ack_rx = 1; @(negedge clk); ack_rx = 0; ack_fp = 0;

        // R6 / R7 transmit then acknowledgement expires
        warmup = 12'd96; flen = 8'd5;
        @(negedge clk); seq_wr = 1; seq_code = 4; e0 = evt;
        @(negedge clk); seq_wr = 0;
        chk("R6 ack timeout exact", cmpv, e0 + 92);
        tx_done = 1; @(negedge clk); tx_done = 0;
        expect_done("R7 ack timeout", 4'b0100);
        wait_sb(1000);
        chk("R7 disarmed after timeout", cmp_en, 0);

        // R7 receive timeout via host arm
        @(negedge clk); arm_req = 1; arm_dur = 20; e0 = evt;
        @(negedge clk); arm_req = 0;
        chk("R10 host arm", cmpv, e0 + 20);
        start(1);
        expect_done("R7 rx timeout", 4'b0100);
        wait_sb(300);

        // R7 plain transmit ignores the hit
        @(negedge clk); arm_req = 1; arm_dur = 5;
        @(negedge clk); arm_req = 0;
        start(2);
        repeat (10 * DIV) @(negedge clk);
        chk("R7 plain tx not cut", code_o, 2);
        expect_done("R7 plain tx end", 4'b0000);
        tx_done = 1; @(negedge clk); tx_done = 0;

        // R7 stop disabled; R11 abort input
        tmo_en = 0;
        @(negedge clk); arm_req = 1; arm_dur = 5;
        @(negedge clk); arm_req = 0;
        start(1);
        repeat (10 * DIV) @(negedge clk);
        chk("R7 stop disabled", code_o, 1);
        abort = 1; @(negedge clk); abort = 0;
        chk("R11 abort idle", code_o, 0);
        chk("R11 abort disarms", cmp_en, 0);

        // R10 refused re-arm one symbol before the hit
        @(negedge clk); arm_req = 1; arm_dur = 1; e0 = evt;
        @(negedge clk); arm_dur = 50;
        @(negedge clk); arm_req = 0;
        chk("R10 rearm refused", cmpv, e0 + 1);
        abort = 1; @(negedge clk); abort = 0;
        tmo_en = 1;

        // R8 unlock beats completion
        start(1);
        expect_done("R8 unlock", 4'b0010);
        unlock = 1; rx_frame = 1; @(negedge clk); unlock = 0; rx_frame = 0;

        // R7 frame in the hit cycle completes normally
        @(negedge clk); arm_req = 1; arm_dur = 3;
        @(negedge clk); arm_req = 0;
        start(1);
        for (int i = 0; i < 100 && evt != cmpv; i++) @(negedge clk);
        expect_done("R7 frame wins over hit", 4'b0000);
        rx_frame = 1; @(negedge clk); rx_frame = 0;
        wait_sb(10);

        finished = 1;
        report();
    end
endmodule